// File: doc/BRIEF.md
# Serial-Loaded Quad Wiper Register Bank

This block is the digital control core of a four-channel, 64-step digitally controlled resistor. A host sends 8-bit command words over a three-wire serial link (active-low select, serial clock, serial data in). Each accepted word carries a channel number and a wiper tap code. The code is stored in that channel's 6-bit holding register and drives the channel's tap output. The analog ladder that the codes steer is outside this block.

The serial lines are sampled by the block's system clock, and serial clock edges are found by edge detection. The link therefore has to run well below the system clock rate. A serial data output taps the far end of the shift register, so several devices can share one select line in a chain. A shutdown input parks every channel in its open-A, wiper-to-B state while the stored codes are kept. A synchronous active-low reset presets every channel to midscale (20h).

Top module: `wiper_bank_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every stored code becomes 20h and `sdo` becomes 0. Reset takes priority over any register write in that cycle.
- R2: A word is shifted in MSB first on rising `sclk` edges while `cs_n` is low. When `cs_n` rises, bits 7:6 select the channel (value n selects channel n) and bits 5:0 become that channel's code. Channel n's code appears on `tap_code[6n+5:6n]`.
- R3: Rising `sclk` edges while `cs_n` is high are ignored. The shift register keeps its contents and no stored code changes.
- R4: If the number of rising `sclk` edges in a select window is zero or not a multiple of 8, no stored code changes when `cs_n` rises.
- R5: If the count is a nonzero multiple of 8, only the last 8 bits received are decoded and written.
- R6: `sdo` changes only after a falling `sclk` edge inside a select window. It then shows the shift register's last stage, so after the k-th falling edge (k ≥ 8) it equals the bit shifted in on the (k−7)-th rising edge.
- R7: While `shdn_n` is low, every `tap_code` field reads 0 and every `shdn_flag` bit reads 1. After release, each channel again shows the code it held before.
- R8: A write changes exactly one channel. The other channels keep their codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset, presets codes to midscale |
| cs_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| shdn_n | input | 1 | Active-low shutdown |
| sdo | output | 1 | Serial data out for chaining |
| tap_code | output | 24 | Four 6-bit tap codes, channel 0 in the low bits |
| shdn_flag | output | 4 | Per-channel shutdown indication |

## Verification
On every cycle, the assertions check the following: the stored codes hold still except on a decoded write strobe, at most one channel is enabled per write, the shift register is frozen while the select is high, `sdo` moves only after a detected falling serial edge, and shutdown forces the parked output state. Only the bench's scenarios can show that decoding is correct: MSB-first order, channel selection from the top bits, rejection of short or ragged frames, last-word selection in a 16-bit chained frame, the eight-edge lag of `sdo` against the input stream, and codes surviving a shutdown.

// File: rtl/wiper_pkg.sv
// Shared constants for the quad wiper register bank.
package wiper_pkg;
    localparam int DEF_NCH = 4;   // channel count
    localparam int DEF_CW  = 6;   // code width per channel

    // Midscale value for a code of the given width: only the top bit set.
    function automatic logic [31:0] midscale(input int cw);
        return 32'd1 << (cw - 1);
    endfunction
endpackage

// File: rtl/wb_front.sv
// Serial front end: registers cs_n, sclk and sdi in the system clock domain
// and produces one-cycle pulses for serial clock edges and the select release.
// Assumes the serial lines are steady for at least two system clocks per phase.
module wb_front (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdi_s,
    output logic rise,
    output logic fall,
    output logic cs_rise,
    output logic cs_idle
);
    logic sclk_r, sclk_p, cs_r, cs_p;

    // Capture the serial lines and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_r <= 1'b0;
            sclk_p <= 1'b0;
            cs_r   <= 1'b1;
            cs_p   <= 1'b1;
            sdi_s  <= 1'b0;
        end else begin
            sclk_r <= sclk;
            sclk_p <= sclk_r;
            cs_r   <= cs_n;
            cs_p   <= cs_r;
            sdi_s  <= sdi;
        end
    end

    // Edge pulses; serial edges count only inside a select window.
    always_comb begin
        rise    = sclk_r & ~sclk_p & ~cs_r;
        fall    = ~sclk_r & sclk_p & ~cs_r;
        cs_rise = cs_r & ~cs_p;
        cs_idle = cs_r;
    end
endmodule

// File: rtl/wb_shifter.sv
// Shift register, frame-length counter and chaining output.
// Shifts MSB first on each detected rising edge and updates sdo from the last
// stage on each detected falling edge. word_ok is high when a nonzero
// multiple of WW edges has been counted in the current window.
module wb_shifter #(
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sdi_s,
    input  logic          rise,
    input  logic          fall,
    input  logic          cs_idle,
    output logic [WW-1:0] shreg,
    output logic          sdo,
    output logic          word_ok
);
    localparam int CNTW = (WW > 1) ? $clog2(WW) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(WW - 1);

    logic [CNTW-1:0] cnt;
    logic            seen;

    // Shift register: takes a new bit on each rising serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (rise) shreg <= {shreg[WW-2:0], sdi_s};
    end

    // Edge counter modulo WW; cleared while the select is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (rise) begin
            cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
            seen <= 1'b1;
        end
    end

    // Chaining output: presents the last stage after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    sdo <= 1'b0;
        else if (fall) sdo <= shreg[WW-1];
    end

    // Frame is whole when at least one edge came and the count wrapped to zero.
    always_comb word_ok = seen && (cnt == '0);
endmodule

// File: rtl/wb_bank.sv
// Per-channel holding registers. On a write strobe, the channel named by addr
// takes code. Reset presets all channels to midscale and overrides a write.
module wb_bank #(
    parameter int NCH = 4,
    parameter int CW  = 6,
    parameter int AW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [AW-1:0]     addr,
    input  logic [CW-1:0]     code,
    output logic [NCH-1:0]    wr_en,
    output logic [NCH*CW-1:0] held
);
    localparam logic [CW-1:0] MID = CW'(wiper_pkg::midscale(CW));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Decode: this channel is enabled when the strobe names it.
        always_comb wr_en[i] = wr_stb && (addr == AW'(i));

        // Holding register for channel i.
        always_ff @(posedge clk) begin
            if (!rst_n)        held[i*CW +: CW] <= MID;
            else if (wr_en[i]) held[i*CW +: CW] <= code;
        end
    end
endmodule

// File: rtl/wiper_bank_top.sv
// Top: serial front end, shifter and register bank. The shutdown mapping is
// applied to the outputs, so stored codes are untouched by shutdown.
module wiper_bank_top #(
    parameter int NCH = wiper_pkg::DEF_NCH,
    parameter int CW  = wiper_pkg::DEF_CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              shdn_n,
    output logic              sdo,
    output logic [NCH*CW-1:0] tap_code,
    output logic [NCH-1:0]    shdn_flag
);
    localparam int AW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int WW = AW + CW;

    logic              sdi_s, rise, fall, cs_rise, cs_idle, word_ok, wr_stb;
    logic [WW-1:0]     shreg;
    logic [NCH-1:0]    wr_en;
    logic [NCH*CW-1:0] held;

    wb_front u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdi_s(sdi_s), .rise(rise), .fall(fall), .cs_rise(cs_rise), .cs_idle(cs_idle)
    );

    wb_shifter #(.WW(WW)) u_shift (
        .clk(clk), .rst_n(rst_n), .sdi_s(sdi_s), .rise(rise), .fall(fall),
        .cs_idle(cs_idle), .shreg(shreg), .sdo(sdo), .word_ok(word_ok)
    );

    // Write strobe: select released after a whole number of words.
    always_comb wr_stb = cs_rise && word_ok;

    wb_bank #(.NCH(NCH), .CW(CW), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
        .addr(shreg[WW-1 -: AW]), .code(shreg[CW-1:0]),
        .wr_en(wr_en), .held(held)
    );

    // Output mapping: shutdown parks the wiper at terminal B (code 0).
    always_comb begin
        tap_code  = shdn_n ? held : '0;
        shdn_flag = {NCH{~shdn_n}};
    end
endmodule

// File: rtl/wb_checker.sv
// Cycle-level properties of the wiper bank, bound into the top module.
module wb_checker #(
    parameter int NCH = 4,
    parameter int CW  = 6,
    parameter int WW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shdn_n,
    input logic              sdo,
    input logic              fall,
    input logic              cs_idle,
    input logic              wr_stb,
    input logic [WW-1:0]     shreg,
    input logic [NCH-1:0]    wr_en,
    input logic [NCH*CW-1:0] held,
    input logic [NCH*CW-1:0] tap_code,
    input logic [NCH-1:0]    shdn_flag
);
    localparam logic [CW-1:0] MID = CW'(wiper_pkg::midscale(CW));

    assert_reset_mid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (held == {NCH{MID}}));

    assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(held));

    assert_idle_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> $stable(shreg));

    assert_sdo_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(fall));

    assert_shutdown_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> (tap_code == '0 && shdn_flag == {NCH{1'b1}}));

    assert_single_channel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));
endmodule

bind wiper_bank_top wb_checker #(.NCH(NCH), .CW(CW), .WW(WW)) u_chk (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .sdo(sdo), .fall(fall),
    .cs_idle(cs_idle), .wr_stb(wr_stb), .shreg(shreg), .wr_en(wr_en),
    .held(held), .tap_code(tap_code), .shdn_flag(shdn_flag)
);

// File: tb/sim_wiper_bank_top.sv
module sim_wiper_bank_top;
    localparam int NCH = 4;
    localparam int CW  = 6;
    localparam int HOLD = 4;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, shdn_n = 1'b1;
    logic sdo;
    logic [NCH*CW-1:0] tap_code;
    logic [NCH-1:0] shdn_flag;

    int n_run = 0, n_fail = 0;
    logic [CW-1:0] model [NCH];
    logic hist [$];

    // Stimulus table: {channel, code}.
    localparam logic [7:0] VEC [8] = '{
        {2'd0, 6'h15}, {2'd3, 6'h3F}, {2'd1, 6'h00}, {2'd2, 6'h2A},
        {2'd0, 6'h01}, {2'd3, 6'h20}, {2'd2, 6'h1F}, {2'd1, 6'h3E}
    };

    always #5 clk = ~clk;

    wiper_bank_top u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .shdn_n(shdn_n), .sdo(sdo), .tap_code(tap_code), .shdn_flag(shdn_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit; checks sdo against the bit 8 edges earlier when known.
    task automatic send_bit(input logic b, input bit check_sdo);
        sdi = b;
        wait_clk(HOLD);
        sclk = 1'b1;
        hist.push_back(b);
        wait_clk(HOLD);
        sclk = 1'b0;
        wait_clk(HOLD);
        if (check_sdo && hist.size() >= 8)
            chk(sdo == hist[hist.size()-8], "R6", sdo, hist[hist.size()-8]);
    endtask

    task automatic send_word(input logic [7:0] w, input bit check_sdo);
        for (int i = 7; i >= 0; i--) send_bit(w[i], check_sdo);
    endtask

    task automatic open_frame;
        cs_n = 1'b0;
        hist.delete();
        wait_clk(HOLD);
    endtask

    task automatic close_frame;
        cs_n = 1'b1;
        wait_clk(HOLD);
    endtask

    task automatic chk_all(input string req);
        for (int c = 0; c < NCH; c++)
            chk(tap_code[c*CW +: CW] == model[c], req, tap_code[c*CW +: CW], model[c]);
    endtask

    initial begin
        wait_clk(200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) model[c] = 6'h20;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: reset state
        chk_all("R1");
        chk(sdo == 1'b0, "R1", sdo, 0);

        // R2/R8: table walk, every channel compared after each write
        for (int v = 0; v < 8; v++) begin
            open_frame();
            send_word(VEC[v], 1'b0);
            close_frame();
            model[VEC[v][7:6]] = VEC[v][5:0];
            chk_all("R2_R8");
        end

        // R3: clocks with select high are ignored; shift state seen via sdo
        open_frame();
        send_word({2'd1, 6'h2A}, 1'b0);
        close_frame();
        model[1] = 6'h2A;
        for (int i = 0; i < 8; i++) begin
            sdi = 1'b0; wait_clk(HOLD); sclk = 1'b1; wait_clk(HOLD); sclk = 1'b0; wait_clk(HOLD);
        end
        chk_all("R3");
        // R4: a one-bit frame writes nothing; sdo exposes old bit 6 (=1)
        open_frame();
        send_bit(1'b0, 1'b0);
        chk(sdo == 1'b1, "R3", sdo, 1);
        close_frame();
        chk_all("R4");

        // R4: ragged 12-bit frame and empty frame write nothing
        open_frame();
        send_word({2'd0, 6'h33}, 1'b0);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        close_frame();
        chk_all("R4");
        open_frame();
        close_frame();
        chk_all("R4");

        // R5/R6: 16-bit chained frame; last word wins, sdo lags by 8 edges
        open_frame();
        send_word({2'd2, 6'h11}, 1'b1);
        send_word({2'd3, 6'h3E}, 1'b1);
        close_frame();
        model[3] = 6'h3E;
        chk_all("R5");

        // R7: shutdown parks outputs and keeps codes
        shdn_n = 1'b0;
        wait_clk(1);
        chk(tap_code == '0, "R7", tap_code, 0);
        chk(shdn_flag == 4'hF, "R7", shdn_flag, 4'hF);
        shdn_n = 1'b1;
        wait_clk(1);
        chk(shdn_flag == 4'h0, "R7", shdn_flag, 0);
        chk_all("R7");

        // R1: reset in mid-operation returns all channels to midscale
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        for (int c = 0; c < NCH; c++) model[c] = 6'h20;
        chk_all("R1");
        chk(sdo == 1'b0, "R1", sdo, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule